// File: doc/BRIEF.md
# Two-Phase Microcoded Control Sequencer

This block sequences a small 4-bit accumulator processor. Each instruction takes two clock steps. In the first step the instruction byte is captured and the program counter moves forward. In the second step the instruction does its work. A phase bit alternates every clock and selects between the two steps.

The phase bit, the two ALU flags (carry and equal) and the 4-bit opcode together form a 7-bit microcode address. A purely combinational case table maps that address to a 16-bit control word for the datapath. The word controls the operand bus, the accumulator and flag loads, the program counter, the ALU function, the carry-in, the data-memory strobes and the I/O port strobes.

The table is indexed directly by the flags, so every conditional jump is resolved by the table row itself. No separate branch logic is needed. Two control bits, the carry-in and the ALU logic/arithmetic mode, are tied by the table layout to opcode bits 3 and 2. The datapath, the ALU and the memories lie outside the block and see only the control word.

Top module: `ucode_ctrl`

## Requirements
- R1: While `rst_i` is high, the control word is the quiet word, whatever the opcode and flags. In the quiet word every active-low strobe is 1, `pc_inc` (bit 3) is 0 and the ALU select (bits 10:7) is 0000. A rising clock edge with `rst_i` high leaves `phase_o` at 0.
- R2: With `rst_i` low, `phase_o` inverts on every rising clock edge. The first edge after reset takes it from 0 to 1.
- R3: In phase 0 the word is the same for every opcode and flag value: fetch load (bit 15) is 0, `pc_inc` (bit 3) is 1, and all other strobes are inactive with select 0000.
- R4: In phase 1, a jump that is taken drives bit 3 (`pc_inc`) to 0 and bit 4 (`pc_ld_n`) to 0. A jump that is not taken drives both bits to 1, which skips the address byte. The jumps are JMP 0x2 (always taken), JC 0x3 (taken when C=1), JNC 0x6 (taken when C=0), JE 0x8 (taken when E=1) and JNE 0x9 (taken when E=0).
- R5: At every address, and also during reset, bit 5 (`cin_n`, the active-low carry-in) equals opcode bit 3, and bit 6 (`alu_m`, logic mode) equals opcode bit 2.
- R6: In phase 1 of a jump, the operand enable (bit 0), accumulator load (bit 1), flag load (bit 2) and every memory, port and fetch strobe are inactive, and the select is 0000.
- R7: In phase 1 the add opcodes give one fixed word whatever C and E are. ADDI (0xA) gives select 1001 with bits 0, 1 and 2 low. ADDM (0xB) gives select 1001 with bits 11 (`mem_oe_n`), 1 and 2 low.
- R8: In phase 1 the compare opcodes load the flags (bit 2 low), leave the accumulator load (bit 1) high and use select 0110. CMPI (0x0) drives the operand bus (bit 0 low) and CMPM (0x1) reads memory (bit 11 low).
- R9: In phase 1 the NOR opcodes use select 0001 and load both the accumulator and the flags (bits 1 and 2 low). NORI (0x4) takes the operand bus and NORM (0x5) takes memory.
- R10: In phase 1, select 1010 passes a value into the accumulator (bit 1 low, flags not loaded) for these three opcodes: LD (0x7) from memory (bit 11 low), LIT (0xD) from the operand bus (bit 0 low) and IN (0xF) from a port (bit 13 low). ST (0xC) pulses only `mem_we_n` (bit 12) and OUT (0xE) pulses only `port_out_n` (bit 14), both with select 0000.
- R11: In phase 1 of every opcode that is not a jump, `pc_inc` is 1 and `pc_ld_n` is 1.
- R12: `uaddr_o` equals {phase, E, C, opcode}, so the opcode sits in bits 3:0, C in bit 4, E in bit 5 and the phase in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 4 | Opcode bits of the fetched instruction |
| flag_c_i | input | 1 | ALU carry flag |
| flag_e_i | input | 1 | ALU equal flag |
| phase_o | output | 1 | Current step: 0 fetch, 1 execute |
| uaddr_o | output | 7 | Microcode address {phase, E, C, opcode} |
| ctrl_o | output | 16 | Control word: [15] fetch_ld_n, [14] port_out_n, [13] port_in_n, [12] mem_we_n, [11] mem_oe_n, [10:7] alu_sel, [6] alu_m, [5] cin_n, [4] pc_ld_n, [3] pc_inc, [2] flg_ld_n, [1] acc_ld_n, [0] opnd_oe_n |

## Verification
The only state in the block is the phase bit. If it is wrong, every following instruction executes its fetch row and its work row swapped. This shows at the ports on the very next edge: a fetch strobe appears where a work strobe belongs, and `phase_o` fails to alternate. A wrong table row is combinational, so it shows in the same cycle its address is presented. The bench therefore visits all 128 addresses in both phases and compares every field. It also checks each conditional jump's taken-or-skip outcome on both values of its flag.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int OP_W  = 4;
  localparam int SEL_W = 4;
  localparam int UA_W  = OP_W + 3;
  localparam int CW_W  = 16;

  localparam int UA_C_BIT  = OP_W;
  localparam int UA_E_BIT  = OP_W + 1;
  localparam int UA_PH_BIT = OP_W + 2;

  typedef enum logic [OP_W-1:0] {
    OP_CMPI = 4'h0, OP_CMPM = 4'h1, OP_JMP  = 4'h2, OP_JC   = 4'h3,
    OP_NORI = 4'h4, OP_NORM = 4'h5, OP_JNC  = 4'h6, OP_LD   = 4'h7,
    OP_JE   = 4'h8, OP_JNE  = 4'h9, OP_ADDI = 4'hA, OP_ADDM = 4'hB,
    OP_ST   = 4'hC, OP_LIT  = 4'hD, OP_OUT  = 4'hE, OP_IN   = 4'hF
  } opcode_e;

  localparam logic [SEL_W-1:0] SEL_IDLE = 4'h0;
  localparam logic [SEL_W-1:0] SEL_NOR  = 4'h1;
  localparam logic [SEL_W-1:0] SEL_SUB  = 4'h6;
  localparam logic [SEL_W-1:0] SEL_ADD  = 4'h9;
  localparam logic [SEL_W-1:0] SEL_PASS = 4'hA;

  typedef struct packed {
    logic             fetch_ld_n;
    logic             port_out_n;
    logic             port_in_n;
    logic             mem_we_n;
    logic             mem_oe_n;
    logic [SEL_W-1:0] alu_sel;
    logic             alu_m;
    logic             cin_n;
    logic             pc_ld_n;
    logic             pc_inc;
    logic             flg_ld_n;
    logic             acc_ld_n;
    logic             opnd_oe_n;
  } ctrl_t;

  // All strobes off; the two layout-tied bits follow the opcode.
  function automatic ctrl_t quiet_word(input logic [OP_W-1:0] op);
    ctrl_t w;
    w            = '1;
    w.alu_sel    = SEL_IDLE;
    w.pc_inc     = 1'b0;
    w.cin_n      = op[3];
    w.alu_m      = op[2];
    return w;
  endfunction

  function automatic ctrl_t fetch_word(input logic [OP_W-1:0] op);
    ctrl_t w;
    w            = quiet_word(op);
    w.fetch_ld_n = 1'b0;
    w.pc_inc     = 1'b1;
    return w;
  endfunction

  function automatic ctrl_t step_word(input logic [OP_W-1:0] op);
    ctrl_t w;
    w        = quiet_word(op);
    w.pc_inc = 1'b1;
    return w;
  endfunction

  function automatic ctrl_t jump_word(input logic [OP_W-1:0] op, input logic taken);
    ctrl_t w;
    w         = quiet_word(op);
    w.pc_inc  = ~taken;
    w.pc_ld_n = ~taken;
    return w;
  endfunction

  function automatic logic is_jump(input logic [OP_W-1:0] op);
    case (opcode_e'(op))
      OP_JMP, OP_JC, OP_JNC, OP_JE, OP_JNE: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ucode_phase.sv
module ucode_phase (
  input  logic clk_i,
  input  logic rst_i,
  output logic phase_o
);
  logic phase_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) phase_q <= 1'b0;
    else       phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;

  // R1: reset clears the step bit
  a_r1_phase_clear: assert property (@(posedge clk_i) rst_i |=> !phase_q);
  // R2: the step bit alternates each clock out of reset
  a_r2_phase_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> phase_q != $past(phase_q));
endmodule

// File: rtl/ucode_addr.sv
module ucode_addr
  import ucode_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  input  logic            flag_c_i,
  input  logic            flag_e_i,
  input  logic            phase_i,
  output logic [UA_W-1:0] uaddr_o
);
  always_comb begin
    uaddr_o                = '0;
    uaddr_o[OP_W-1:0]      = opcode_i;
    uaddr_o[UA_C_BIT]      = flag_c_i;
    uaddr_o[UA_E_BIT]      = flag_e_i;
    uaddr_o[UA_PH_BIT]     = phase_i;
  end
endmodule

// File: rtl/ucode_table.sv
module ucode_table
  import ucode_pkg::*;
(
  input  logic [UA_W-1:0] uaddr_i,
  output ctrl_t           word_o,
  output logic            jump_o,
  output logic            taken_o
);
  logic [OP_W-1:0] op;
  logic            fc, fe, ph;

  assign op = uaddr_i[OP_W-1:0];
  assign fc = uaddr_i[UA_C_BIT];
  assign fe = uaddr_i[UA_E_BIT];
  assign ph = uaddr_i[UA_PH_BIT];

  always_comb begin
    word_o  = quiet_word(op);
    jump_o  = 1'b0;
    taken_o = 1'b0;
    if (!ph) begin
      word_o = fetch_word(op);
    end else begin
      case (opcode_e'(op))
        OP_JMP: begin jump_o = 1'b1; taken_o = 1'b1; word_o = jump_word(op, 1'b1); end
        OP_JC:  begin jump_o = 1'b1; taken_o = fc;   word_o = jump_word(op, fc);   end
        OP_JNC: begin jump_o = 1'b1; taken_o = ~fc;  word_o = jump_word(op, ~fc);  end
        OP_JE:  begin jump_o = 1'b1; taken_o = fe;   word_o = jump_word(op, fe);   end
        OP_JNE: begin jump_o = 1'b1; taken_o = ~fe;  word_o = jump_word(op, ~fe);  end
        OP_ADDI: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_ADD; word_o.opnd_oe_n = 1'b0;
          word_o.acc_ld_n = 1'b0;   word_o.flg_ld_n = 1'b0;
        end
        OP_ADDM: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_ADD; word_o.mem_oe_n = 1'b0;
          word_o.acc_ld_n = 1'b0;   word_o.flg_ld_n = 1'b0;
        end
        OP_CMPI: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_SUB; word_o.opnd_oe_n = 1'b0; word_o.flg_ld_n = 1'b0;
        end
        OP_CMPM: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_SUB; word_o.mem_oe_n = 1'b0; word_o.flg_ld_n = 1'b0;
        end
        OP_NORI: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_NOR; word_o.opnd_oe_n = 1'b0;
          word_o.acc_ld_n = 1'b0;   word_o.flg_ld_n = 1'b0;
        end
        OP_NORM: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_NOR; word_o.mem_oe_n = 1'b0;
          word_o.acc_ld_n = 1'b0;   word_o.flg_ld_n = 1'b0;
        end
        OP_LD: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_PASS; word_o.mem_oe_n = 1'b0; word_o.acc_ld_n = 1'b0;
        end
        OP_LIT: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_PASS; word_o.opnd_oe_n = 1'b0; word_o.acc_ld_n = 1'b0;
        end
        OP_IN: begin
          word_o = step_word(op);
          word_o.alu_sel = SEL_PASS; word_o.port_in_n = 1'b0; word_o.acc_ld_n = 1'b0;
        end
        OP_ST: begin
          word_o = step_word(op);
          word_o.mem_we_n = 1'b0;
        end
        OP_OUT: begin
          word_o = step_word(op);
          word_o.port_out_n = 1'b0;
        end
        default: word_o = quiet_word(op);
      endcase
    end
  end
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            flag_c_i,
  input  logic            flag_e_i,
  output logic            phase_o,
  output logic [UA_W-1:0] uaddr_o,
  output logic [CW_W-1:0] ctrl_o
);
  logic            phase_w;
  logic [UA_W-1:0] uaddr_w;
  ctrl_t           tbl_w;
  ctrl_t           out_w;
  logic            jump_w;
  logic            taken_w;

  ucode_phase u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .phase_o (phase_w)
  );

  ucode_addr u_addr (
    .opcode_i (opcode_i),
    .flag_c_i (flag_c_i),
    .flag_e_i (flag_e_i),
    .phase_i  (phase_w),
    .uaddr_o  (uaddr_w)
  );

  ucode_table u_table (
    .uaddr_i (uaddr_w),
    .word_o  (tbl_w),
    .jump_o  (jump_w),
    .taken_o (taken_w)
  );

  assign out_w   = rst_i ? quiet_word(opcode_i) : tbl_w;
  assign phase_o = phase_w;
  assign uaddr_o = uaddr_w;
  assign ctrl_o  = out_w;

  // R1: reset keeps every strobe off
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |-> (out_w.acc_ld_n && out_w.flg_ld_n && out_w.pc_ld_n && !out_w.pc_inc
               && out_w.mem_we_n && out_w.port_out_n && out_w.fetch_ld_n));
  // R3: fetch step never loads the datapath
  a_r3_fetch_only: assert property (@(posedge clk_i) disable iff (rst_i)
    !phase_w |-> (!out_w.fetch_ld_n && out_w.pc_inc && out_w.pc_ld_n
                  && out_w.acc_ld_n && out_w.flg_ld_n && out_w.mem_we_n));
  // R4: a jump either loads the PC or increments it, never both nor neither
  a_r4_jump_pc: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_w && jump_w) |-> (out_w.pc_inc == out_w.pc_ld_n) && (out_w.pc_ld_n == !taken_w));
  // R5: layout-tied bits track opcode bits 3 and 2
  a_r5_tied_bits: assert property (@(posedge clk_i)
    (out_w.cin_n == opcode_i[3]) && (out_w.alu_m == opcode_i[2]));
  // R6: jumps leave the ALU path idle
  a_r6_jump_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_w && jump_w) |-> (out_w.acc_ld_n && out_w.flg_ld_n && out_w.opnd_oe_n
                             && out_w.alu_sel == SEL_IDLE && out_w.mem_oe_n));
  // R11: non-jumps step past their second byte
  a_r11_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_w && !jump_w) |-> (out_w.pc_inc && out_w.pc_ld_n));
endmodule

// File: tb/ucode_ctrl_tb.sv
module ucode_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = 4'hA;
  logic        fc  = 1'b0;
  logic        fe  = 1'b0;
  logic        phase;
  logic [6:0]  uaddr;
  logic [15:0] ctrl;
  logic        exp_ph = 1'b0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  ucode_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .opcode_i(op), .flag_c_i(fc), .flag_e_i(fe),
    .phase_o(phase), .uaddr_o(uaddr), .ctrl_o(ctrl)
  );

  // Expected phase from R1/R2
  always @(posedge clk) exp_ph <= rst ? 1'b0 : ~exp_ph;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s op=%h c=%b e=%b ph=%b actual=%h expected=%h", tag, op, fc, fe, phase, act, exp);
    end
  endtask

  // Independent reference built bit by bit from the requirements
  function automatic logic [15:0] ref_word(input logic [3:0] o, input logic c, input logic e,
                                           input logic p, input logic r);
    logic [15:0] w;
    logic tk;
    w = 16'hF817;
    w[6] = o[2];
    w[5] = o[3];
    if (r) return w;
    if (!p) begin w[15] = 1'b0; w[3] = 1'b1; return w; end
    case (o)
      4'h2, 4'h3, 4'h6, 4'h8, 4'h9: begin
        tk = (o == 4'h2) || (o == 4'h3 && c) || (o == 4'h6 && !c) || (o == 4'h8 && e) || (o == 4'h9 && !e);
        w[3] = !tk; w[4] = !tk;
      end
      default: begin
        w[3] = 1'b1;
        case (o)
          4'hA: begin w[10:7] = 4'b1001; w[0] = 0; w[1] = 0; w[2] = 0; end
          4'hB: begin w[10:7] = 4'b1001; w[11] = 0; w[1] = 0; w[2] = 0; end
          4'h0: begin w[10:7] = 4'b0110; w[0] = 0; w[2] = 0; end
          4'h1: begin w[10:7] = 4'b0110; w[11] = 0; w[2] = 0; end
          4'h4: begin w[10:7] = 4'b0001; w[0] = 0; w[1] = 0; w[2] = 0; end
          4'h5: begin w[10:7] = 4'b0001; w[11] = 0; w[1] = 0; w[2] = 0; end
          4'h7: begin w[10:7] = 4'b1010; w[11] = 0; w[1] = 0; end
          4'hD: begin w[10:7] = 4'b1010; w[0] = 0; w[1] = 0; end
          4'hF: begin w[10:7] = 4'b1010; w[13] = 0; w[1] = 0; end
          4'hC: w[12] = 1'b0;
          4'hE: w[14] = 1'b0;
          default: ;
        endcase
      end
    endcase
    return w;
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic p);
    if (!p) return "R3";
    case (o)
      4'h2, 4'h3, 4'h6, 4'h8, 4'h9: return "R4/R6";
      4'hA, 4'hB: return "R7";
      4'h0, 4'h1: return "R8";
      4'h4, 4'h5: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 phase", {15'd0, phase}, 16'd0);
    check("R1 word", ctrl, ref_word(op, fc, fe, 1'b0, 1'b1));
    op = 4'h8; fe = 1'b1; #1;
    check("R1 jump held", ctrl, 16'hF817 | {9'd0, 1'b0, 1'b1, 5'd0});
    check("R5 in reset", {14'd0, ctrl[6], ctrl[5]}, {14'd0, op[2], op[3]});
    @(negedge clk);
    rst = 1'b0; #1;
    check("R2 starts at 0", {15'd0, phase}, 16'd0);
  endtask

  task automatic t_phase;
    logic prev;
    prev = phase;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check("R2 toggle", {15'd0, phase}, {15'd0, ~prev});
      check("R2 model", {15'd0, phase}, {15'd0, exp_ph});
      prev = phase;
    end
  endtask

  task automatic t_sweep;
    for (int o = 0; o < 16; o++) begin
      for (int c = 0; c < 2; c++) begin
        for (int e = 0; e < 2; e++) begin
          @(negedge clk);
          op = o[3:0]; fc = c[0]; fe = e[0];
          for (int s = 0; s < 2; s++) begin
            if (s == 1) @(negedge clk);
            #1;
            check(tag_of(op, exp_ph), ctrl, ref_word(op, fc, fe, exp_ph, 1'b0));
            check("R12 uaddr", {9'd0, uaddr}, {9'd0, exp_ph, fe, fc, op});
            check("R5 tied", {14'd0, ctrl[6], ctrl[5]}, {14'd0, op[2], op[3]});
            if (exp_ph && !(op == 4'h2 || op == 4'h3 || op == 4'h6 || op == 4'h8 || op == 4'h9))
              check("R11 step", {14'd0, ctrl[4], ctrl[3]}, 16'd3);
          end
        end
      end
    end
  endtask

  task automatic t_jumps;
    logic [3:0] jops [5] = '{4'h2, 4'h3, 4'h6, 4'h8, 4'h9};
    for (int j = 0; j < 5; j++) begin
      for (int f = 0; f < 2; f++) begin
        @(negedge clk);
        if (!exp_ph) @(negedge clk);
        op = jops[j]; fc = f[0]; fe = f[0]; #1;
        // taken -> {pc_ld_n,pc_inc} = 00, skip -> 11
        case (op)
          4'h2: check("R4 JMP",  {14'd0, ctrl[4], ctrl[3]}, 16'd0);
          4'h3: check("R4 JC",   {14'd0, ctrl[4], ctrl[3]}, fc ? 16'd0 : 16'd3);
          4'h6: check("R4 JNC",  {14'd0, ctrl[4], ctrl[3]}, fc ? 16'd3 : 16'd0);
          4'h8: check("R4 JE",   {14'd0, ctrl[4], ctrl[3]}, fe ? 16'd0 : 16'd3);
          default: check("R4 JNE", {14'd0, ctrl[4], ctrl[3]}, fe ? 16'd3 : 16'd0);
        endcase
        check("R6 jump idle", {ctrl[15:7], ctrl[2:0]}, {5'b11111, 4'b0000, 3'b111});
      end
    end
  endtask

  task automatic t_add_flags;
    logic [15:0] first;
    @(negedge clk);
    if (!exp_ph) @(negedge clk);
    op = 4'hA; fc = 1'b0; fe = 1'b0; #1;
    first = ctrl;
    for (int f = 1; f < 4; f++) begin
      fc = f[0]; fe = f[1]; #1;
      check("R7 flag independent", ctrl, first);
    end
  endtask

  initial begin
    t_reset();
    t_phase();
    t_sweep();
    t_jumps();
    t_add_flags();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule